// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block follows a rotary or linear incremental encoder. It takes the two phase signals, A and B, straight from the pins. Each phase passes through a synchronizer. The block then decodes the valid Gray-code steps and moves an up/down counter by one position on each step. The counter runs between zero and a programmable ceiling and wraps at either end. Every wrap raises a sticky update flag. The flag reaches the interrupt line only while the update-interrupt enable is set.

A configuration write sets three things: the decoding resolution, the ceiling and the interrupt enable. It also presets the counter to half of the ceiling, rounded down. From that preset the position can move in both directions from a reading of zero. Each read returns the count minus that midpoint as a 32-bit two's-complement value. A read-and-reset returns the same value and reloads the midpoint in the same clock. An encoder step that lands in that same cycle is applied on top of the reloaded midpoint, so no step is lost. The block has two resolutions. The double resolution counts both edges of phase A. The quadruple resolution counts both edges of both phases. A configuration write that carries any other resolution code is discarded as a whole.

Top module: `qenc_counter`

## Requirements
- R1: After reset the counter is disabled, the resolution is quadruple (code 3), the ceiling is all ones, the count is the ceiling divided by two, the flag and interrupt are low, and a read returns 0.
- R2: With resolution code 3, every single-phase change moves the count by one. The order (A,B) 00→10→11→01→00 counts up and the reverse order counts down.
- R3: With resolution code 2, only changes of phase A move the count. A change to A≠B counts up and a change to A=B counts down. Changes of B alone are ignored.
- R4: A configuration write with a resolution code other than 2 or 3 is discarded. Resolution, ceiling, interrupt enable and count all keep their previous values.
- R5: An accepted configuration write loads the count with floor(ceiling/2).
- R6: A read request returns, in the following cycle with the read-valid strobe high, the count minus floor(ceiling/2) as a signed 32-bit value.
- R7: A read-and-reset request returns the same value as a read and reloads the count with floor(ceiling/2) in the same cycle.
- R8: A step up from the ceiling wraps to 0, and a step down from 0 wraps to the ceiling. Either wrap sets the update flag.
- R9: The interrupt output is high only while the update flag and the interrupt enable are both set. A clear request drops the flag unless a wrap happens in the same cycle.
- R10: While counting is disabled, encoder steps leave the count unchanged.
- R11: A change of both phases between two samples counts as invalid and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Resolution code (2 = double, 3 = quadruple) |
| cfg_max | input | CW | Counter ceiling |
| cfg_irq_en | input | 1 | Update-interrupt enable |
| run_we | input | 1 | Counting-enable write strobe |
| run_val | input | 1 | Counting-enable value |
| flag_clr | input | 1 | Clear the update flag |
| rd_req | input | 1 | Read request |
| rd_rst | input | 1 | Read-and-reset request |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Signed position relative to the midpoint |
| upd_flag | output | 1 | Sticky wrap flag |
| irq | output | 1 | Interrupt request |

## Verification
Wrapping in both directions is hard to reach with the reset ceiling, because reaching the ends would take tens of thousands of encoder steps. The stimulus therefore writes a small ceiling of 6, which presets the count to 3. It then walks the phases three steps to reach the top and one more to wrap to zero. After a flag clear it steps down once to wrap back to the ceiling. A rejected configuration write comes before this sequence, and the unchanged count and unchanged resolution show that the write was discarded.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    typedef enum logic [1:0] {
        RES_X2 = 2'd2,
        RES_X4 = 2'd3
    } res_e;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2
    } step_e;

    function automatic logic res_legal(input logic [1:0] code);
        return (code == 2'd2) || (code == 2'd3);
    endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= din[i];
                s2 <= s1;
            end
        end
        assign dout[i] = s2;
    end
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
    import qenc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  a_s,
    input  logic  b_s,
    input  res_e  res,
    output step_e step
);
    logic a_p, b_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_p <= 1'b0;
            b_p <= 1'b0;
        end else begin
            a_p <= a_s;
            b_p <= b_s;
        end
    end

    logic a_chg, b_chg;
    assign a_chg = a_s ^ a_p;
    assign b_chg = b_s ^ b_p;

    always_comb begin
        step = STEP_NONE;
        if (a_chg && !b_chg) begin
            step = (a_s ^ b_s) ? STEP_UP : STEP_DN;
        end else if (b_chg && !a_chg && res == RES_X4) begin
            step = (a_s ^ b_s) ? STEP_DN : STEP_UP;
        end
    end
endmodule

// File: rtl/qenc_core.sv
module qenc_core
    import qenc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  step_e         step,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_mode,
    input  logic [CW-1:0] cfg_max,
    input  logic          cfg_irq_en,
    input  logic          run_we,
    input  logic          run_val,
    input  logic          flag_clr,
    input  logic          rd_rst,
    output logic [CW-1:0] count,
    output logic [CW-1:0] max_q,
    output res_e          res_q,
    output logic          run_q,
    output logic          irq_en_q,
    output logic          flag_q
);
    logic [CW-1:0] mid;
    logic [CW-1:0] base;
    logic [CW-1:0] nxt;
    logic          wrap;
    logic          cfg_ok;

    assign mid    = max_q >> 1;
    assign cfg_ok = cfg_we && res_legal(cfg_mode);
    assign base   = rd_rst ? mid : count;

    always_comb begin
        nxt  = base;
        wrap = 1'b0;
        if (run_q) begin
            if (step == STEP_UP) begin
                if (base >= max_q) begin
                    nxt  = '0;
                    wrap = 1'b1;
                end else begin
                    nxt = base + 1'b1;
                end
            end else if (step == STEP_DN) begin
                if (base == '0) begin
                    nxt  = max_q;
                    wrap = 1'b1;
                end else begin
                    nxt = base - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            max_q    <= '1;
            res_q    <= RES_X4;
            irq_en_q <= 1'b0;
            run_q    <= 1'b0;
            count    <= {1'b0, {(CW-1){1'b1}}};
            flag_q   <= 1'b0;
        end else begin
            if (run_we) run_q <= run_val;
            if (cfg_ok) begin
                max_q    <= cfg_max;
                res_q    <= res_e'(cfg_mode);
                irq_en_q <= cfg_irq_en;
                count    <= cfg_max >> 1;
            end else begin
                count <= nxt;
            end
            if (wrap && !cfg_ok) flag_q <= 1'b1;
            else if (flag_clr)   flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int CW = 16,
    localparam int RW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enc_a,
    input  logic          enc_b,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_mode,
    input  logic [CW-1:0] cfg_max,
    input  logic          cfg_irq_en,
    input  logic          run_we,
    input  logic          run_val,
    input  logic          flag_clr,
    input  logic          rd_req,
    input  logic          rd_rst,
    output logic          rd_valid,
    output logic [RW-1:0] rd_data,
    output logic          upd_flag,
    output logic          irq
);
    logic [1:0]    ph_s;
    step_e         step;
    logic [CW-1:0] count, max_q;
    res_e          res_q;
    logic          run_q, irq_en_q, flag_q;

    qenc_sync #(.N(2)) u_sync (
        .clk (clk), .rst (rst),
        .din ({enc_a, enc_b}),
        .dout(ph_s)
    );

    qenc_decode u_dec (
        .clk (clk), .rst (rst),
        .a_s (ph_s[1]), .b_s (ph_s[0]),
        .res (res_q),
        .step(step)
    );

    qenc_core #(.CW(CW)) u_core (
        .clk       (clk), .rst (rst),
        .step      (step),
        .cfg_we    (cfg_we),
        .cfg_mode  (cfg_mode),
        .cfg_max   (cfg_max),
        .cfg_irq_en(cfg_irq_en),
        .run_we    (run_we),
        .run_val   (run_val),
        .flag_clr  (flag_clr),
        .rd_rst    (rd_rst),
        .count     (count),
        .max_q     (max_q),
        .res_q     (res_q),
        .run_q     (run_q),
        .irq_en_q  (irq_en_q),
        .flag_q    (flag_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req || rd_rst;
            if (rd_req || rd_rst)
                rd_data <= RW'(count) - RW'(max_q >> 1);
        end
    end

    assign upd_flag = flag_q;
    assign irq      = flag_q && irq_en_q;
endmodule

module qenc_counter_chk
    import qenc_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_we,
    input logic          rd_req,
    input logic          rd_rst,
    input logic          rd_valid,
    input logic          run_q,
    input logic          flag_clr,
    input logic          upd_flag,
    input logic          irq,
    input logic [CW-1:0] count,
    input logic [CW-1:0] max_q,
    input res_e          res_q
);
    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        count <= max_q);  // R8
    AST_RES_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (res_q == RES_X2) || (res_q == RES_X4));  // R4
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !cfg_we && !rd_rst) |=> count == $past(count));  // R10
    AST_READ_STROBE: assert property (@(posedge clk) disable iff (rst)
        (rd_req || rd_rst) |=> rd_valid);  // R6
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> upd_flag);  // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (upd_flag && !flag_clr) |=> upd_flag);  // R9
endmodule

bind qenc_counter qenc_counter_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .rd_req(rd_req), .rd_rst(rd_rst),
    .rd_valid(rd_valid), .run_q(run_q), .flag_clr(flag_clr),
    .upd_flag(upd_flag), .irq(irq), .count(count), .max_q(max_q),
    .res_q(res_q)
);

// File: tb/qenc_counter_bench.sv
module qenc_counter_bench;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enc_a = 1'b0, enc_b = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_mode = 2'd3;
    logic [CW-1:0] cfg_max = '0;
    logic          cfg_irq_en = 1'b0;
    logic          run_we = 1'b0, run_val = 1'b0;
    logic          flag_clr = 1'b0;
    logic          rd_req = 1'b0, rd_rst = 1'b0;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic          upd_flag, irq;

    always #2 clk = ~clk;

    qenc_counter #(.CW(CW)) u_qenc_counter (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b),
        .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_max(cfg_max),
        .cfg_irq_en(cfg_irq_en), .run_we(run_we), .run_val(run_val),
        .flag_clr(flag_clr), .rd_req(rd_req), .rd_rst(rd_rst),
        .rd_valid(rd_valid), .rd_data(rd_data), .upd_flag(upd_flag), .irq(irq)
    );

    int tests = 0;
    int fails = 0;

    // bench reference model
    int  m_cnt, m_max, m_res;
    bit  m_run, m_ien, m_flag;

    typedef struct { int val; string tag; } exp_t;
    exp_t sb[$];

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops expected read results
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (sb.size() == 0) begin
                check("R6 unexpected read", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, $signed(rd_data), e.val);
            end
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic read(input string tag, input bit reset);
        exp_t e;
        e.val = m_cnt - m_max / 2;
        e.tag = tag;
        sb.push_back(e);
        rd_req = !reset;
        rd_rst = reset;
        if (reset) m_cnt = m_max / 2;
        tick(1);
        rd_req = 1'b0;
        rd_rst = 1'b0;
        tick(1);
    endtask

    task automatic configure(input int mode, input int mx, input bit ien);
        cfg_we = 1'b1; cfg_mode = 2'(mode); cfg_max = CW'(mx); cfg_irq_en = ien;
        tick(1);
        cfg_we = 1'b0;
        if (mode == 2 || mode == 3) begin
            m_res = mode; m_max = mx; m_ien = ien; m_cnt = mx / 2;
        end
        tick(1);
    endtask

    task automatic set_run(input bit v);
        run_we = 1'b1; run_val = v;
        tick(1);
        run_we = 1'b0;
        m_run = v;
    endtask

    // drive new phases, update the model from the requirement rules
    task automatic move(input bit na, input bit nb);
        bit ac, bc;
        int d;
        ac = (na != enc_a);
        bc = (nb != enc_b);
        d = 0;
        if (ac && !bc) d = (na != nb) ? 1 : -1;
        else if (bc && !ac && m_res == 3) d = (na != nb) ? -1 : 1;
        enc_a = na;
        enc_b = nb;
        if (m_run && d == 1) begin
            if (m_cnt == m_max) begin m_cnt = 0; m_flag = 1; end
            else m_cnt++;
        end else if (m_run && d == -1) begin
            if (m_cnt == 0) begin m_cnt = m_max; m_flag = 1; end
            else m_cnt--;
        end
        tick(4);
    endtask

    // one forward quadrature step from the current phase pair
    task automatic fwd(input int n);
        for (int i = 0; i < n; i++) begin
            case ({enc_a, enc_b})
                2'b00: move(1, 0);
                2'b10: move(1, 1);
                2'b11: move(0, 1);
                default: move(0, 0);
            endcase
        end
    endtask

    task automatic rev(input int n);
        for (int i = 0; i < n; i++) begin
            case ({enc_a, enc_b})
                2'b00: move(0, 1);
                2'b01: move(1, 1);
                2'b11: move(1, 0);
                default: move(0, 0);
            endcase
        end
    endtask

    initial begin
        m_cnt = 32'h7FFF; m_max = 32'hFFFF; m_res = 3;
        m_run = 0; m_ien = 0; m_flag = 0;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        check("R1 flag after reset", upd_flag, 0);
        check("R1 irq after reset", irq, 0);
        read("R1 reset read", 0);
        rev(2);                                   // R10 disabled after reset
        read("R10 disabled after reset", 0);

        // R5 configure quadruple, ceiling 20
        configure(3, 20, 0);
        set_run(1);
        read("R5 preset midpoint", 0);
        fwd(4);
        read("R2 quadruple up", 0);
        rev(8);
        read("R2 quadruple down", 0);
        move(~enc_a, ~enc_b);                     // R11 both phases change
        read("R11 simultaneous change", 0);
        move(~enc_a, ~enc_b);

        // R3 double resolution
        configure(2, 20, 0);
        fwd(4);
        read("R3 double full cycle", 0);
        rev(2);
        read("R3 double reverse", 0);

        // R4 illegal code rejected
        configure(1, 50, 1);
        read("R4 count kept", 0);
        fwd(2);
        read("R4 resolution kept", 0);

        // R10 disable
        set_run(0);
        fwd(3);
        read("R10 hold when disabled", 0);
        set_run(1);

        // R7 read-and-reset
        fwd(4);
        read("R7 read-and-reset value", 1);
        read("R7 after reload", 0);

        // R8/R9 wrap with small ceiling
        configure(3, 6, 1);
        fwd(3);
        read("R8 at ceiling", 0);
        check("R8 no flag at ceiling", upd_flag, 0);
        fwd(1);
        read("R8 wrap up", 0);
        check("R8 flag on up wrap", upd_flag, m_flag);
        check("R9 irq with enable", irq, 1);
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0; m_flag = 0; tick(1);
        check("R9 flag cleared", upd_flag, 0);
        check("R9 irq cleared", irq, 0);
        rev(1);
        read("R8 wrap down", 0);
        check("R8 flag on down wrap", upd_flag, 1);

        // R9 gating with enable off, odd ceiling
        configure(3, 7, 0);
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0; tick(1);
        m_flag = 0;
        fwd(5);
        check("R9 flag without enable", upd_flag, 1);
        check("R9 irq gated", irq, 0);
        read("R5 odd ceiling midpoint", 0);

        tick(4);
        check("R6 all reads returned", sb.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule